// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block generates one or two pulse-width modulated outputs, each set up through a small bank of memory-mapped registers. Each channel first divides its input clock with a 6-bit prescaler, giving a divide ratio of P+1. It then counts the divided ticks from 0 up to a 10-bit period value V. The output is high while the position inside the period is below the duty count DC, and low for the rest of the period. A full-duty flag overrides DC and holds the output high for the whole period. A shutdown bit, or a low channel enable, stops the channel and clears its counters.

Register writes go to holding registers. The counters copy these values only while the channel is idle, or in the last clock of a period. A write made part-way through a period therefore never changes the period that is running. The second channel's bank uses the same layout as the first and sits 0x10 above it. The register port is a plain byte address with a write strobe. Read data comes out one clock after the address is presented.

Top module: `pwm_dual_bank`

## Requirements
- R1: Each bank has three registers. The control word at offset 0x00 holds the prescale P in bits 5:0 and the shutdown bit in bit 6. The duty word at 0x04 holds DC in bits 9:0 and the full-duty flag in bit 10. The period word at 0x08 holds V in bits 9:0. A read returns the stored fields in the clock after the address is presented, with every unused bit read as zero. Offset 0x0C, and any address with bits 1:0 not zero, reads as zero and ignores writes.
- R2: The second channel's bank sits at base 0x10 (address bit 4 set). The two channels keep separate settings and run independently of each other.
- R3: One output period lasts (P+1)*(V+1) input clock cycles, for every P from 0 to 63.
- R4: Each period starts with the output high for (P+1)*DC cycles, then low for the rest of the period.
- R5: When the full-duty flag is set, the output stays high for the whole period, whatever DC holds.
- R6: DC = 0 gives an output that is always low. DC > V+1 gives an output that is always high.
- R7: A write made during a period takes effect only from the next period boundary.
- R8: While a channel's enable is low, its output is low and its counters are held at the start of a period. When the enable rises, a new period starts in that same cycle, using the register values already written.
- R9: A set shutdown bit acts the same as a low enable: the output goes low and the counters return to the start of a period.
- R10: A synchronous active-high reset clears every register and counter and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and counters |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte address: bit 4 selects the bank, bits 3:2 select the register |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data, one clock after the address |
| ch_en | input | NUM_CH | Enable for each channel |
| pwm_out | output | NUM_CH | Modulated output of each channel |

## Verification
The bench compares every cycle of the output against a counting model, so an off-by-one in the prescaler or the period wrap changes the length of the waveform and shows up in the comparison. It writes a new duty value in the middle of a period. A design that updates its live counters at once would stretch that period and fail. It runs DC of zero, DC above V+1, the full-duty flag and the largest prescale value. A design that compares positions the wrong way, or ignores the flag, would give a wrong level in those runs. It turns the enable off and back on in the middle of a period, and sets the shutdown bit while the channel runs. A design that keeps its counters across these stops would start the next period part-way through.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W    = 6;
  localparam int CNT_W    = 10;
  localparam int REG_W    = 11;
  localparam int ADDR_W   = 5;
  localparam int SD_BIT   = 6;
  localparam int FULL_BIT = 10;
  localparam int BANK_BIT = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DUTY = 2'd1;
  localparam logic [1:0] SEL_PER  = 2'd2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             sd;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } chan_cfg_t;

  // Output level at a given position inside the period.
  function automatic logic level_at(input logic [CNT_W-1:0] pos,
                                    input logic [CNT_W-1:0] dc,
                                    input logic full);
    return full | (pos < dc);
  endfunction

  // Read word for one register of a bank; unused bits are zero.
  function automatic logic [REG_W-1:0] pack_read(input chan_cfg_t c,
                                                 input logic [1:0] sel);
    case (sel)
      SEL_CTRL: return {{(REG_W-PRE_W-1){1'b0}}, c.sd, c.pre};
      SEL_DUTY: return {c.full, c.dc};
      SEL_PER:  return {{(REG_W-CNT_W){1'b0}}, c.pv};
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output chan_cfg_t        cfg,
  output logic [REG_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          cfg.pre <= wdata[PRE_W-1:0];
          cfg.sd  <= wdata[SD_BIT];
        end
        SEL_DUTY: begin
          cfg.dc   <= wdata[CNT_W-1:0];
          cfg.full <= wdata[FULL_BIT];
        end
        SEL_PER: cfg.pv <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb rd_word = pack_read(cfg, sel);
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  chan_cfg_t cfg,
  output logic      pwm_out
);
  logic             run;
  logic             tick;
  logic             period_end;
  logic [PRE_W-1:0] pre_cnt, pre_act;
  logic [CNT_W-1:0] per_cnt, pv_act, dc_act;
  logic             full_act;

  assign run        = en & ~cfg.sd;
  assign tick       = (pre_cnt == pre_act);
  assign period_end = tick && (per_cnt == pv_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      per_cnt  <= '0;
      pre_act  <= '0;
      pv_act   <= '0;
      dc_act   <= '0;
      full_act <= 1'b0;
    end else if (!run || period_end) begin
      pre_cnt  <= '0;
      per_cnt  <= '0;
      pre_act  <= cfg.pre;
      pv_act   <= cfg.pv;
      dc_act   <= cfg.dc;
      full_act <= cfg.full;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_out = run & level_at(per_cnt, dc_act, full_act);

  // R3: counters never run past the active limits
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre_cnt <= pre_act && per_cnt <= pv_act));
  // R7: active values hold steady within a period
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    (run && !period_end) |=> ($stable(dc_act) && $stable(pv_act) &&
                              $stable(pre_act) && $stable(full_act)));
  // R8: an idle channel sits at the start of a period
  p_idle_reset_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre_cnt == '0 && per_cnt == '0));
  // R6: zero duty without the flag never drives high
  p_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
    (dc_act == '0 && !full_act) |-> !pwm_out);
endmodule

// File: rtl/pwm_dual_bank.sv
module pwm_dual_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int MAX_CH = 2;

  logic             aligned;
  logic             bank;
  logic [1:0]       sel;
  logic [REG_W-1:0] rd_word [MAX_CH];

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign bank    = reg_addr[BANK_BIT];
  assign sel     = reg_addr[3:2];

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      chan_cfg_t cfg;
      pwm_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we && aligned && (bank == 1'(c))),
        .sel     (sel),
        .wdata   (reg_wdata),
        .cfg     (cfg),
        .rd_word (rd_word[c])
      );
      pwm_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .en      (ch_en[c]),
        .cfg     (cfg),
        .pwm_out (pwm_out[c])
      );
    end else begin : g_off
      assign rd_word[c] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (aligned && (int'(bank) < NUM_CH)) reg_rdata <= rd_word[bank];
    else reg_rdata <= '0;
  end

  // R1: misaligned addresses read as zero
  p_rd_blank_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_addr[1:0] != 2'b00) |=> (reg_rdata == '0));
endmodule

// File: tb/test_pwm_dual_bank.sv
module test_pwm_dual_bank;
  import pwm_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic [1:0]       ch_en = 2'b00;
  logic [1:0]       pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_dual_bank #(.NUM_CH(2)) i_pwm_dual_bank (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_en(ch_en), .pwm_out(pwm_out)
  );

  // {pre, pv, dc, full}
  localparam logic [26:0] VEC [7] = '{
    {6'd0,  10'd4, 10'd2, 1'b0},
    {6'd2,  10'd3, 10'd1, 1'b0},
    {6'd1,  10'd5, 10'd0, 1'b0},
    {6'd0,  10'd3, 10'd9, 1'b0},
    {6'd3,  10'd2, 10'd1, 1'b1},
    {6'd0,  10'd0, 10'd1, 1'b0},
    {6'd63, 10'd1, 10'd1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model(input int k, input int p, input int v,
                               input int d, input bit f);
    int pos;
    pos = (k / (p + 1)) % (v + 1);
    return f || (pos < d);
  endfunction

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = REG_W'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    reg_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    chk(reg_rdata == REG_W'(exp), tag, int'(reg_rdata), exp);
  endtask

  task automatic run_vec(input int ch, input int p, input int v, input int d,
                         input bit f, input string tag);
    int base, bad, ncyc, first_k;
    base = ch * 16;
    wr(base + 0, p);
    wr(base + 4, (int'(f) << 10) | d);
    wr(base + 8, v);
    ncyc = 2 * (p + 1) * (v + 1) + 3;
    bad = 0; first_k = -1;
    @(posedge clk); #1;
    ch_en[ch] = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (pwm_out[ch] != model(k, p, v, d, f) || pwm_out[1-ch] != 1'b0) begin
        bad++;
        if (first_k < 0) first_k = k;
      end
    end
    chk(bad == 0, tag, first_k, -1);
    @(posedge clk); #1;
    ch_en[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(pwm_out == 2'b00, "R10 outputs low after reset", int'(pwm_out), 0);
    rd(4, 0, "R10 duty register cleared");

    // R1: readback with unused bits zero
    wr(0, 11'h7FF);  rd(0, 11'h07F, "R1 control readback");
    wr(4, 11'h7FF);  rd(4, 11'h7FF, "R1 duty readback");
    wr(8, 11'h7FF);  rd(8, 11'h3FF, "R1 period readback");
    rd(12, 0, "R1 offset 0x0C reads zero");
    wr(9, 11'h055);  rd(8, 11'h3FF, "R1 misaligned write ignored");
    rd(9, 0, "R1 misaligned read zero");
    // R2: second bank independent
    wr(16 + 8, 11'h123); rd(24, 11'h123, "R2 second bank period");
    rd(8, 11'h3FF, "R2 first bank untouched");
    wr(0, 0); wr(16, 0);

    // Table of patterns, alternating channels
    for (int i = 0; i < 7; i++) begin
      run_vec(i % 2, int'(VEC[i][26:21]), int'(VEC[i][20:11]),
              int'(VEC[i][10:1]), VEC[i][0],
              $sformatf("R3 R4 R5 R6 R2 pattern %0d", i));
    end

    // R7: mid-period duty write
    begin
      int bad;
      bad = 0;
      wr(0, 0); wr(8, 7); wr(4, 2);
      @(posedge clk); #1; ch_en[0] = 1'b1;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (pwm_out[0] != ((k < 8) ? (k < 2) : ((k - 8) < 6))) bad++;
        if (k == 2) begin reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 11'd6; end
        if (k == 3) reg_we = 1'b0;
      end
      chk(bad == 0, "R7 write applies at next period", bad, 0);
      @(posedge clk); #1; ch_en[0] = 1'b0;
    end

    // R8: disable mid-period restarts the period
    begin
      int bad;
      bad = 0;
      wr(8, 3); wr(4, 2);
      @(posedge clk); #1; ch_en[0] = 1'b1;
      repeat (3) @(negedge clk);
      @(posedge clk); #1; ch_en[0] = 1'b0;
      @(negedge clk);
      chk(pwm_out[0] == 1'b0, "R8 disabled output low", int'(pwm_out[0]), 0);
      @(posedge clk); #1; ch_en[0] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (pwm_out[0] != (k < 2)) bad++;
      end
      chk(bad == 0, "R8 restart from period start", bad, 0);
      @(posedge clk); #1; ch_en[0] = 1'b0;
    end

    // R9: shutdown bit
    wr(4, 11'h400); wr(8, 3);
    @(posedge clk); #1; ch_en[0] = 1'b1;
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R9 running before shutdown", int'(pwm_out[0]), 1);
    wr(0, 11'h040);
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R9 shutdown forces low", int'(pwm_out[0]), 0);
    wr(0, 0);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R9 resumes after shutdown cleared", int'(pwm_out[0]), 1);

    // R10: reset while running
    @(posedge clk); #1; rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == 2'b00, "R10 reset while running", int'(pwm_out), 0);
    ch_en = 2'b00;
    rd(8, 0, "R10 period cleared by reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule